// File: doc/BRIEF.md
# Interrupt Aggregator for a Small Microcontroller

This block gathers the interrupt sources of an 8-bit microcontroller and reduces them to a CPU interrupt request and a wake-from-sleep request. Three sources are owned by the block: an external pin with a selectable active edge, a timer rollover detector, and a change detector over a masked group of port pins. In addition, a vector of peripheral flags with matching enables arrives from outside and is merged under one peripheral enable bit.

Software controls the block through a small byte-wide register bus. The bus reaches a control register that holds the enables and the three sticky flags, an option register that holds the edge-select bit, a pin mask register, and a port snapshot location. Reading the snapshot location returns the synchronized pins and re-arms the change detector. Wake-up needs only a source's own enable. A branch to the fixed vector also needs the global enable.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the control register (bus_sel 0) reads 00h, the option register (bus_sel 1) reads 40h (bit 6 = edge select, 1 = rising) and the mask register (bus_sel 2) reads 00h. irq_req and wake_req are low.
- R2: A synchronized rising edge of ext_pin sets control bit 1 when the edge-select bit is 1, and a falling edge sets it when the bit is 0. The opposite edge leaves bit 1 unchanged.
- R3: A tmr_count change from all-ones to zero between consecutive clocks sets control bit 2. Any other change leaves bit 2 unchanged.
- R4: While a port pin's bit in the mask register is 1 and its synchronized level differs from the stored snapshot, control bit 0 is set. Differences on pins whose mask bit is 0 leave bit 0 unchanged.
- R5: A read of bus_sel 3 returns the synchronized pins in the low bits and loads the snapshot with them. In the clock of that read no change is detected, so a pin change that first reaches the detector in that clock sets no flag.
- R6: Flags (control bits 2..0) are cleared only by a control write with 0 in that bit. A hardware set event in the same clock as such a write leaves the flag at 1.
- R7: wake_req is 1 exactly when some flag is set together with its enable (bit 5 for bit 2, bit 4 for bit 1, bit 3 for bit 0) or the peripheral request is active. irq_req and vec_take equal wake_req ANDed with control bit 7 (global enable).
- R8: The peripheral request is control bit 6 ANDed with the OR of per_flags & per_enables.
- R9: vec_addr always presents the vector address 0004h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | PORT_W | Port pins watched for change, asynchronous |
| tmr_count | input | TMR_W | Current count of the free-running timer |
| per_flags | input | NPER | Peripheral interrupt flags |
| per_enables | input | NPER | Peripheral interrupt enables |
| bus_sel | input | 2 | Register select: 0 control, 1 option, 2 mask, 3 port snapshot |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake_req | output | 1 | Wake-up request from sleep |
| vec_take | output | 1 | Branch to the interrupt vector after wake-up |
| vec_addr | output | VEC_W | Interrupt vector address |

## Verification
The hardest case is the lost-change window: a pin change must reach the synchronizer output in exactly the clock in which software reads the port. The bench steps the pin on a falling edge and starts the read on the second falling edge after it. It then confirms that the returned snapshot already holds the new level and that the change flag stays clear. The set-beats-clear collision is reached in a similar way: the timer is held at all-ones, and on the same falling edge it is driven to zero and a control write that clears the flag is issued.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int BUS_W    = 8;
   localparam int OPT_EDGE = 6;

   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_OPT  = 2'd1,
      REG_MASK = 2'd2,
      REG_PORT = 2'd3
   } reg_sel_e;

   // bit 7 down to bit 0
   typedef struct packed {
      logic glb_en;
      logic per_en;
      logic tmr_en;
      logic ext_en;
      logic chg_en;
      logic tmr_f;
      logic ext_f;
      logic chg_f;
   } ctl_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage[i] <= '0;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic rise_sel,
   output logic hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign hit = rise_sel ? (level & ~prev_q) : (~level & prev_q);
endmodule

// File: rtl/irq_rollover_det.sv
module irq_rollover_det #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] count,
   output logic         hit
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= count;
   end

   assign hit = (prev_q == {W{1'b1}}) && (count == '0);
endmodule

// File: rtl/irq_change_det.sv
module irq_change_det #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] mask,
   input  logic         snap,
   output logic         hit
);
   logic [W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= '0;
      else if (snap) held_q <= level;
   end

   assign hit = ~snap & (|((level ^ held_q) & mask));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int PORT_W      = 6,
   parameter int TMR_W       = 8,
   parameter int NPER        = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 13,
   parameter int VEC_ADDR    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic [PORT_W-1:0] port_pins,
   input  logic [TMR_W-1:0]  tmr_count,
   input  logic [NPER-1:0]   per_flags,
   input  logic [NPER-1:0]   per_enables,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_req,
   output logic              wake_req,
   output logic              vec_take,
   output logic [VEC_W-1:0]  vec_addr
);
   localparam int SYNC_W = PORT_W + 1;

   if (PORT_W < 1 || PORT_W > BUS_W) begin : g_bad_port
      $error("PORT_W must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TMR_W < 2) begin : g_bad_tmr
      $error("TMR_W must be at least 2");
   end
   if (NPER < 1) begin : g_bad_per
      $error("NPER must be at least 1");
   end
   if (VEC_W < 3) begin : g_bad_vec
      $error("VEC_W too small for the vector address");
   end

   ctl_t              ctl_q, ctl_d;
   logic              edge_rise_q;
   logic [PORT_W-1:0] mask_q;
   logic [SYNC_W-1:0] synced;
   logic              ext_s;
   logic [PORT_W-1:0] pins_s;
   logic              ext_hit, tmr_hit, chg_hit;
   logic              wr_ctl, wr_opt, wr_mask, rd_port;
   logic              per_req, any_src;

   assign wr_ctl  = bus_wr && (bus_sel == REG_CTL);
   assign wr_opt  = bus_wr && (bus_sel == REG_OPT);
   assign wr_mask = bus_wr && (bus_sel == REG_MASK);
   assign rd_port = bus_rd && (bus_sel == REG_PORT);

   irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_pin, port_pins}),
      .q     (synced)
   );
   assign ext_s  = synced[PORT_W];
   assign pins_s = synced[PORT_W-1:0];

   irq_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (ext_s),
      .rise_sel (edge_rise_q),
      .hit      (ext_hit)
   );

   irq_rollover_det #(.W(TMR_W)) u_roll (
      .clk   (clk),
      .rst_n (rst_n),
      .count (tmr_count),
      .hit   (tmr_hit)
   );

   irq_change_det #(.W(PORT_W)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pins_s),
      .mask  (mask_q),
      .snap  (rd_port),
      .hit   (chg_hit)
   );

   // software write first, hardware set events override it
   always_comb begin
      ctl_d = ctl_q;
      if (wr_ctl) ctl_d = ctl_t'(bus_wdata);
      if (tmr_hit) ctl_d.tmr_f = 1'b1;
      if (ext_hit) ctl_d.ext_f = 1'b1;
      if (chg_hit) ctl_d.chg_f = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q       <= '0;
         edge_rise_q <= 1'b1;
         mask_q      <= '0;
      end else begin
         ctl_q <= ctl_d;
         if (wr_opt)  edge_rise_q <= bus_wdata[OPT_EDGE];
         if (wr_mask) mask_q      <= bus_wdata[PORT_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_sel)
         REG_CTL:  bus_rdata = ctl_q;
         REG_OPT:  bus_rdata[OPT_EDGE] = edge_rise_q;
         REG_MASK: bus_rdata[PORT_W-1:0] = mask_q;
         REG_PORT: bus_rdata[PORT_W-1:0] = pins_s;
         default:  bus_rdata = '0;
      endcase
   end

   assign per_req  = ctl_q.per_en & (|(per_flags & per_enables));
   assign any_src  = (ctl_q.tmr_en & ctl_q.tmr_f)
                   | (ctl_q.ext_en & ctl_q.ext_f)
                   | (ctl_q.chg_en & ctl_q.chg_f)
                   | per_req;
   assign wake_req = any_src;
   assign irq_req  = ctl_q.glb_en & any_src;
   assign vec_take = ctl_q.glb_en & wake_req;
   assign vec_addr = VEC_W'(VEC_ADDR);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int PORT_W = 6,
   parameter int TMR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        ctl,
   input logic [PORT_W-1:0] mask,
   input logic [TMR_W-1:0]  tmr_count,
   input logic [1:0]        bus_sel,
   input logic              bus_wr,
   input logic              irq_req,
   input logic              wake_req
);
   logic armed;
   logic wr_ctl;

   assign wr_ctl = bus_wr && (bus_sel == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_irq_needs_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wake_req);

   assert_irq_needs_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ctl[7]);

   assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (|($past(ctl[2:0]) & ~ctl[2:0]))) |-> $past(wr_ctl));

   assert_rollover_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(tmr_count) == {TMR_W{1'b1}}) && (tmr_count == '0)) |=> ctl[2]);

   assert_change_needs_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(ctl[0]) && ctl[0]) |-> ($past(wr_ctl) || ($past(mask) != '0)));
endmodule

bind irq_aggregator irq_aggregator_chk #(.PORT_W(PORT_W), .TMR_W(TMR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl       (ctl_q),
   .mask      (mask_q),
   .tmr_count (tmr_count),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .irq_req   (irq_req),
   .wake_req  (wake_req)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 6;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_pin = 1'b0;
   logic [PW-1:0] port_pins = '0;
   logic [7:0]    tmr_count = '0;
   logic [NP-1:0] per_flags = '0;
   logic [NP-1:0] per_enables = '0;
   logic [1:0]    bus_sel = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          irq_req, wake_req, vec_take;
   logic [12:0]   vec_addr;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [7:0]    m_ctl = '0;
   logic          m_rise = 1'b1;
   logic [PW-1:0] m_mask = '0;
   logic [PW-1:0] m_latch = '0;
   logic [7:0]    m_tmr = '0;

   irq_aggregator dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
      .tmr_count(tmr_count), .per_flags(per_flags), .per_enables(per_enables),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_req(irq_req), .wake_req(wake_req),
      .vec_take(vec_take), .vec_addr(vec_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_wake();
      return (|(m_ctl[5:3] & m_ctl[2:0])) | (m_ctl[6] & (|(per_flags & per_enables)));
   endfunction

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      bus_sel = s; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic apply_chg();
      if (((port_pins ^ m_latch) & m_mask) != '0) m_ctl[0] = 1'b1;
   endtask

   task automatic full_check(input string req);
      logic [7:0] d;
      #1;
      chk({req, " wake_req"}, wake_req, exp_wake());
      chk({req, " irq_req"},  irq_req,  m_ctl[7] & exp_wake());
      chk({req, " vec_take"}, vec_take, m_ctl[7] & exp_wake());
      rd(2'd0, d);
      chk({req, " control"}, d, m_ctl);
   endtask

   task automatic op_wctl(input logic [7:0] v);
      wr(2'd0, v); m_ctl = v; settle(); apply_chg();
   endtask
   task automatic op_wopt(input logic r);
      wr(2'd1, {1'b0, r, 6'd0}); m_rise = r; settle();
   endtask
   task automatic op_wmask(input logic [PW-1:0] m);
      wr(2'd2, {2'b00, m}); m_mask = m; settle(); apply_chg();
   endtask
   task automatic op_rport(input string req);
      logic [7:0] d;
      rd(2'd3, d);
      chk({req, " port snapshot data"}, d, {2'b00, port_pins});
      m_latch = port_pins; settle();
   endtask
   task automatic op_ext(input logic v);
      @(negedge clk);
      if (v != ext_pin && v == m_rise) m_ctl[1] = 1'b1;
      ext_pin = v; settle();
   endtask
   task automatic op_pins(input logic [PW-1:0] p);
      @(negedge clk); port_pins = p; settle(); apply_chg();
   endtask
   task automatic op_tmr(input logic [7:0] v);
      @(negedge clk);
      if (m_tmr == 8'hFF && v == 8'h00) m_ctl[2] = 1'b1;
      m_tmr = v; tmr_count = v;
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 irq_req at reset", irq_req, 1'b0);
      chk("R1 wake_req at reset", wake_req, 1'b0);
      rst_n = 1'b1;
      rd(2'd0, d); chk("R1 control reset", d, 8'h00);
      rd(2'd1, d); chk("R1 option reset", d, 8'h40);
      rd(2'd2, d); chk("R1 mask reset", d, 8'h00);
      chk("R9 vector address", vec_addr, 13'h0004);

      // R2 external edge, rising then falling selection
      op_wctl(8'h10);
      op_ext(1'b1); full_check("R2 rising edge sets flag");
      chk("R7 wake without global enable", wake_req, 1'b1);
      chk("R7 no irq without global enable", irq_req, 1'b0);
      op_wctl(8'h10);
      op_ext(1'b0); full_check("R2 falling edge ignored when rising selected");
      op_wopt(1'b0);
      op_ext(1'b1); full_check("R2 rising edge ignored when falling selected");
      op_ext(1'b0); full_check("R2 falling edge sets flag");
      repeat (20) @(negedge clk);
      full_check("R6 flag sticky");
      op_wctl(8'h90); full_check("R6 write clears flag");
      op_wctl(8'h92); full_check("R7 irq with global enable");
      op_wctl(8'h00); op_wopt(1'b1);

      // R3 timer rollover
      op_wctl(8'h20);
      op_tmr(8'hFE); op_tmr(8'hFF); op_tmr(8'h01); settle();
      full_check("R3 FF to 01 no flag");
      op_tmr(8'hFF); op_tmr(8'h00); settle();
      full_check("R3 rollover sets flag");
      // R6 set beats clear in the same clock
      op_tmr(8'hFF); @(negedge clk);
      tmr_count = 8'h00; m_tmr = 8'h00;
      bus_sel = 2'd0; bus_wdata = 8'h20; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      m_ctl = 8'h24; settle();
      full_check("R6 set wins over clear");

      // R4 / R5 port change
      op_wctl(8'h08);
      op_wmask(6'h01);
      op_pins(6'h02); full_check("R4 unmasked pin change ignored");
      op_pins(6'h03); full_check("R4 masked pin change sets flag");
      op_rport("R5");
      op_wctl(8'h08); full_check("R5 snapshot refresh stops flag");
      op_wmask(6'h3F); op_rport("R5"); op_wctl(8'h08);
      @(negedge clk); port_pins = 6'h2B;
      @(negedge clk);
      rd(2'd3, d);
      chk("R5 read in detection clock returns new pins", d, 8'h2B);
      m_latch = 6'h2B; settle();
      full_check("R5 change hidden by coincident read");

      // R8 peripheral request
      op_wctl(8'h00);
      @(negedge clk); per_flags = 8'h10; per_enables = 8'h10; #1;
      chk("R8 peripheral gated by its enable", wake_req, 1'b0);
      op_wctl(8'h40); full_check("R8 peripheral wakes");
      op_wctl(8'hC0); full_check("R8 peripheral irq");
      @(negedge clk); per_enables = 8'h0F;
      full_check("R8 mismatched enable");

      // constrained random
      for (int i = 0; i < 300; i++) begin
         int unsigned sel;
         sel = $urandom_range(0, 7);
         case (sel)
            0: op_wctl(8'($urandom));
            1: op_wopt(1'($urandom));
            2: op_wmask(6'($urandom));
            3: op_rport("R5 random");
            4: op_ext(~ext_pin);
            5: op_pins(6'($urandom));
            6: begin
               if ($urandom_range(0, 1) == 0) begin
                  op_tmr(8'hFF); op_tmr(8'h00);
               end else begin
                  op_tmr(8'($urandom)); op_tmr(8'($urandom));
               end
               settle();
            end
            default: begin
               @(negedge clk);
               per_flags = 8'($urandom); per_enables = 8'($urandom);
            end
         endcase
         full_check("R7 random");
      end

      report();
      $finish;
   end
endmodule